// File: doc/BRIEF.md
# Forty-Bit Accumulating Multiply Engine

This block is a multiply-accumulate unit with one internal 40-bit accumulator that is the target of every multiply it performs. Each operation arrives as a 4-bit operation code with two 32-bit register operands and a valid strobe. The supported forms are a dual-lane sum of two signed 16x16 products, a single signed 16x16 product whose operand halves are picked by the code, and a signed 32x32 product cut down to its low 40 bits. There is no memory port. Operands come only from a register-file read path.

Two transfer operations link the accumulator to a pair of 32-bit registers. A load fills all 40 bits from the two operands. A read returns the accumulator on a registered 64-bit write-back port, one cycle later, as two 32-bit words. A synchronous clear input zeroes the accumulator and takes priority over any operation in the same cycle.

Top module: `dsp_acc40_mac`

## Requirements
- R1: While rst_n is low at a clock edge, the accumulator becomes zero and wb_valid becomes 0.
- R2: When clr is 1 at an edge, the accumulator is zero after that edge, whatever operation is presented in the same cycle.
- R3: Code 1 (dual) adds the sum of signed a[15:0]*b[15:0] and signed a[31:16]*b[31:16], sign-extended to 40 bits, to the accumulator.
- R4: Codes 2 to 5 add one signed 16x16 product, sign-extended to 40 bits. The a half comes first and the b half second: 2 is low*low, 3 is a low * b high, 4 is a high * b low, and 5 is high*high.
- R5: Code 6 forms the signed 64-bit product of a and b and adds its low 40 bits to the accumulator.
- R6: Accumulation wraps modulo 2^40 with no saturation.
- R7: Code 7 (load) sets the accumulator to {b[7:0], a[31:0]}.
- R8: Code 8 (read) leaves the accumulator unchanged. After the next edge, wb_valid is 1 for one cycle. wb_data[31:0] then holds accumulator bits 31:0 and wb_data[63:32] holds bits 39:32 sign-extended. Both are the value from before that edge, including when clr is 1 in the same cycle.
- R9: With op_valid low, or with code 0 or 9 to 15, the accumulator does not change and wb_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous accumulator clear |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| wb_valid | output | 1 | Write-back pair valid |
| wb_data | output | 64 | Write-back pair, low word in bits 31:0 |

## Verification
The clear input and a strobed operation can land on the same edge. The bench provokes this twice. In the first case, clr is raised together with a dual multiply after a known value has been loaded, and a following read must return zero. In the second case, clr is raised together with a read. The write-back must carry the value loaded before the clear, and a second read must then return zero.

// File: rtl/dsp_acc40_pkg.sv
// Shared operation codes for the 40-bit accumulating multiply engine.
// Assumes a 4-bit code field; values not listed here are treated as no-ops.
package dsp_acc40_pkg;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        OP_NOP  = 4'd0,
        OP_DUAL = 4'd1,
        OP_LL   = 4'd2,
        OP_LH   = 4'd3,
        OP_HL   = 4'd4,
        OP_HH   = 4'd5,
        OP_WIDE = 4'd6,
        OP_LOAD = 4'd7,
        OP_READ = 4'd8
    } mac_op_e;
endpackage

// File: rtl/dsp_acc40_prod.sv
// Product stage: picks the operand halves for each 16-bit lane, forms the
// signed products and turns the result into a 40-bit addend.
// Assumes ACC_W > 2*HALF_W so that a lane sum fits once sign-extended,
// and ACC_W <= 2*DATA_W so that the wide product can be truncated.
module dsp_acc40_prod
    import dsp_acc40_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic [CODE_W-1:0] op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              add_req,
    output logic [ACC_W-1:0]  addend
);
    localparam int HALF_W = DATA_W / 2;
    localparam int PROD_W = 2 * HALF_W;
    localparam int WIDE_W = 2 * DATA_W;
    localparam int LANES  = 2;

    logic [HALF_W-1:0] lane_x [LANES];
    logic [HALF_W-1:0] lane_y [LANES];
    logic [ACC_W-1:0]  lane_p [LANES];
    logic              hi_a;
    logic              hi_b;

    // Half selection for the single-product codes.
    always_comb begin
        hi_a = (op_code == OP_HL) || (op_code == OP_HH);
        hi_b = (op_code == OP_LH) || (op_code == OP_HH);
    end

    // Lane 0 takes the selected halves; lane 1 is always the high halves.
    always_comb begin
        lane_x[0] = hi_a ? opnd_a[DATA_W-1:HALF_W] : opnd_a[HALF_W-1:0];
        lane_y[0] = hi_b ? opnd_b[DATA_W-1:HALF_W] : opnd_b[HALF_W-1:0];
        lane_x[1] = opnd_a[DATA_W-1:HALF_W];
        lane_y[1] = opnd_b[DATA_W-1:HALF_W];
    end

    // One signed multiplier per lane, sign-extended to accumulator width.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [PROD_W-1:0] prod;
        always_comb begin
            prod      = $signed(lane_x[g]) * $signed(lane_y[g]);
            lane_p[g] = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        end
    end

    logic signed [WIDE_W-1:0] wide_p;

    // Full-width signed product for the wide code.
    always_comb wide_p = $signed(opnd_a) * $signed(opnd_b);

    // Addend mux driven by the operation code.
    always_comb begin
        add_req = 1'b1;
        unique case (op_code)
            OP_DUAL:                   addend = lane_p[0] + lane_p[1];
            OP_LL, OP_LH, OP_HL, OP_HH: addend = lane_p[0];
            OP_WIDE:                   addend = wide_p[ACC_W-1:0];
            default: begin
                addend  = '0;
                add_req = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dsp_acc40_reg.sv
// Accumulator register. Priority order: reset, clear, load, add.
// Assumes load_en and add_en are never high together (the top decodes them
// from a single code).
module dsp_acc40_reg #(
    parameter int ACC_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_en,
    input  logic [ACC_W-1:0] load_val,
    input  logic             add_en,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] acc_q
);
    // Accumulator update with wrap-around addition.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (clr)     acc_q <= '0;
        else if (load_en) acc_q <= load_val;
        else if (add_en)  acc_q <= acc_q + addend;
    end
endmodule

// File: rtl/dsp_acc40_xfer.sv
// Register-pair transfer: builds the 40-bit load value from two operands and
// registers the read-back pair. Assumes DATA_W < ACC_W <= 2*DATA_W.
module dsp_acc40_xfer #(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ACC_W-1:0]    acc_q,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [ACC_W-DATA_W-1:0] opnd_b_lo,
    output logic [ACC_W-1:0]    load_val,
    output logic                wb_valid,
    output logic [2*DATA_W-1:0] wb_data
);
    localparam int EXT_W = ACC_W - DATA_W;
    localparam int PAD_W = DATA_W - EXT_W;

    // Load value: upper bits from the second register, low word from the first.
    always_comb load_val = {opnd_b_lo, opnd_a};

    // Read-back register: one-cycle valid pulse, data held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_data  <= '0;
        end else begin
            wb_valid <= rd_en;
            if (rd_en)
                wb_data <= {{PAD_W{acc_q[ACC_W-1]}}, acc_q[ACC_W-1:DATA_W],
                            acc_q[DATA_W-1:0]};
        end
    end
endmodule

// File: rtl/dsp_acc40_mac.sv
// Top of the 40-bit accumulating multiply engine. Decodes the strobed code
// into add, load and read enables and wires the product stage, accumulator
// and transfer unit together. Assumes operands are stable while op_valid is high.
module dsp_acc40_mac
    import dsp_acc40_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                op_valid,
    input  logic [3:0]          op_code,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [DATA_W-1:0]   opnd_b,
    output logic                wb_valid,
    output logic [2*DATA_W-1:0] wb_data
);
    localparam int EXT_W = ACC_W - DATA_W;

    logic             add_req;
    logic [ACC_W-1:0] addend;
    logic [ACC_W-1:0] load_val;
    logic [ACC_W-1:0] acc_q;
    logic             add_en;
    logic             load_en;
    logic             rd_en;

    // Enable decode gated by the strobe.
    always_comb begin
        add_en  = op_valid && add_req;
        load_en = op_valid && (op_code == OP_LOAD);
        rd_en   = op_valid && (op_code == OP_READ);
    end

    dsp_acc40_prod #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_prod (
        .op_code (op_code),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .add_req (add_req),
        .addend  (addend)
    );

    dsp_acc40_reg #(.ACC_W(ACC_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .load_en  (load_en),
        .load_val (load_val),
        .add_en   (add_en),
        .addend   (addend),
        .acc_q    (acc_q)
    );

    dsp_acc40_xfer #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .acc_q     (acc_q),
        .opnd_a    (opnd_a),
        .opnd_b_lo (opnd_b[EXT_W-1:0]),
        .load_val  (load_val),
        .wb_valid  (wb_valid),
        .wb_data   (wb_data)
    );
endmodule

// File: rtl/dsp_acc40_chk.sv
// Property checker for the accumulating multiply engine, bound to the top.
// Observes ports and the accumulator register.
module dsp_acc40_chk #(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 40
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clr,
    input logic                op_valid,
    input logic [3:0]          op_code,
    input logic [DATA_W-1:0]   opnd_a,
    input logic [DATA_W-1:0]   opnd_b,
    input logic                wb_valid,
    input logic [2*DATA_W-1:0] wb_data,
    input logic [ACC_W-1:0]    acc_q
);
    localparam int EXT_W = ACC_W - DATA_W;

    // R1: reset leaves the write-back strobe low.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !wb_valid);

    // R2: clear wins over everything in its cycle.
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> acc_q == '0);

    // R7: a load takes the operand pair.
    a_r7_load_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !clr && op_code == 4'd7) |=>
        acc_q == {$past(opnd_b[EXT_W-1:0]), $past(opnd_a)});

    // R8: a read is followed by the valid pulse and keeps the accumulator.
    a_r8_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd8) |=> wb_valid);

    a_r8_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !clr && op_code == 4'd8) |=> $stable(acc_q));

    a_r8_upper_sext: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_data[2*DATA_W-1:ACC_W] == {(2*DATA_W-ACC_W){wb_data[ACC_W-1]}});

    // R9: idle and unused codes leave the accumulator alone and raise no strobe.
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (!op_valid || op_code == 4'd0 || op_code > 4'd8)) |=>
        ($stable(acc_q) && !wb_valid));
endmodule

bind dsp_acc40_mac dsp_acc40_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .op_valid (op_valid),
    .op_code  (op_code),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .wb_valid (wb_valid),
    .wb_data  (wb_data),
    .acc_q    (acc_q)
);

// File: tb/sim_dsp_acc40_mac.sv
`timescale 1ns/1ps
module sim_dsp_acc40_mac;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        wb_valid;
    logic [63:0] wb_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [39:0] m_acc = '0;

    always #10 clk = ~clk;

    dsp_acc40_mac u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .op_valid(op_valid),
        .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .wb_valid(wb_valid), .wb_data(wb_data)
    );

    function automatic logic [39:0] p16(input logic [15:0] x, input logic [15:0] y);
        logic signed [31:0] p;
        p = $signed(x) * $signed(y);
        return {{8{p[31]}}, p};
    endfunction

    function automatic logic [39:0] p32(input logic [31:0] x, input logic [31:0] y);
        logic signed [63:0] p;
        p = $signed(x) * $signed(y);
        return p[39:0];
    endfunction

    function automatic logic [63:0] pack(input logic [39:0] v);
        return {{24{v[39]}}, v};
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; opnd_a = a; opnd_b = b;
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd0;
    endtask

    task automatic read_check(input string tag, input logic [39:0] exp);
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd8;
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd0;
        check({tag, " valid"}, {63'd0, wb_valid}, 64'd1);
        check(tag, wb_data, pack(exp));
    endtask

    task automatic t_reset;
        check("R1 wb_valid after reset", {63'd0, wb_valid}, 64'd0);
        read_check("R1 acc after reset", 40'd0);
        @(negedge clk);
        check("R8 pulse one cycle", {63'd0, wb_valid}, 64'd0);
    endtask

    task automatic t_dual;
        issue(4'd1, 32'h0003_FFFE, 32'h0005_0007);
        m_acc = m_acc + p16(16'hFFFE, 16'h0007) + p16(16'h0003, 16'h0005);
        read_check("R3 dual mixed sign", m_acc);
        issue(4'd1, 32'h8000_8000, 32'h8000_8000);
        m_acc = m_acc + p16(16'h8000, 16'h8000) + p16(16'h8000, 16'h8000);
        read_check("R3 dual extreme", m_acc);
    endtask

    task automatic t_halves;
        logic [31:0] a = 32'hFF9C_0011;
        logic [31:0] b = 32'h0123_FFF3;
        issue(4'd7, 32'd0, 32'd0); m_acc = '0;
        issue(4'd2, a, b); m_acc = m_acc + p16(a[15:0], b[15:0]);
        read_check("R4 low*low", m_acc);
        issue(4'd3, a, b); m_acc = m_acc + p16(a[15:0], b[31:16]);
        read_check("R4 a low * b high", m_acc);
        issue(4'd4, a, b); m_acc = m_acc + p16(a[31:16], b[15:0]);
        read_check("R4 a high * b low", m_acc);
        issue(4'd5, a, b); m_acc = m_acc + p16(a[31:16], b[31:16]);
        read_check("R4 high*high", m_acc);
    endtask

    task automatic t_wide;
        issue(4'd6, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        m_acc = m_acc + p32(32'h7FFF_FFFF, 32'h7FFF_FFFF);
        read_check("R5 wide positive truncated", m_acc);
        issue(4'd6, 32'h8000_0001, 32'h1234_5678);
        m_acc = m_acc + p32(32'h8000_0001, 32'h1234_5678);
        read_check("R5 wide negative", m_acc);
    endtask

    task automatic t_wrap;
        issue(4'd7, 32'hFFFF_FFFF, 32'h0000_007F); m_acc = 40'h7F_FFFF_FFFF;
        read_check("R7 load max positive", m_acc);
        issue(4'd2, 32'h0000_0001, 32'h0000_0001);
        read_check("R6 wrap to negative", 40'h80_0000_0000);
        issue(4'd7, 32'hFFFF_FFFF, 32'hABCD_EFFF);
        read_check("R7 load uses b low byte", 40'hFF_FFFF_FFFF);
        issue(4'd2, 32'h0000_0001, 32'h0000_0001);
        read_check("R6 wrap to zero", 40'd0);
        m_acc = '0;
    endtask

    task automatic t_collide;
        issue(4'd7, 32'h3456_789A, 32'h0000_0012);
        @(negedge clk);
        clr = 1'b1; op_valid = 1'b1; op_code = 4'd1;
        opnd_a = 32'h1111_2222; opnd_b = 32'h3333_4444;
        @(negedge clk);
        clr = 1'b0; op_valid = 1'b0; op_code = 4'd0;
        read_check("R2 clear beats dual", 40'd0);
        issue(4'd7, 32'h89AB_CDEF, 32'h0000_00C5);
        @(negedge clk);
        clr = 1'b1; op_valid = 1'b1; op_code = 4'd8;
        @(negedge clk);
        clr = 1'b0; op_valid = 1'b0; op_code = 4'd0;
        check("R8 read with clear returns old", wb_data, pack(40'hC5_89AB_CDEF));
        read_check("R2 clear during read", 40'd0);
        m_acc = '0;
    endtask

    task automatic t_ignored;
        issue(4'd7, 32'h0BAD_F00D, 32'h0000_0042); m_acc = 40'h42_0BAD_F00D;
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd1; opnd_a = 32'h7FFF_7FFF; opnd_b = 32'h7FFF_7FFF;
        @(negedge clk);
        op_code = 4'd0;
        check("R9 no strobe when not valid", {63'd0, wb_valid}, 64'd0);
        issue(4'd0, 32'h7FFF_7FFF, 32'h7FFF_7FFF);
        check("R9 code 0 no strobe", {63'd0, wb_valid}, 64'd0);
        issue(4'd9, 32'h7FFF_7FFF, 32'h7FFF_7FFF);
        issue(4'd15, 32'h7FFF_7FFF, 32'h7FFF_7FFF);
        check("R9 code 15 no strobe", {63'd0, wb_valid}, 64'd0);
        read_check("R9 acc unchanged", m_acc);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dual();
        t_halves();
        t_wide();
        t_wrap();
        t_collide();
        t_ignored();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule